// File: doc/BRIEF.md
# Direct-Mapped Cache Controller

This block sits between a processor word port and a slower main memory. It keeps a table of lines, where each line holds a valid flag, a tag and a block of several 32-bit words. Every memory block can live in exactly one line: the line number is the block address modulo the number of lines. A read that hits returns its word in the same cycle. A write that hits updates the cached word and also writes the word through to main memory. While that write is in progress, the processor is held.

On a miss the processor is stalled. The controller fetches the whole block from memory in one read transaction and installs it with its new tag. The held request is then taken again and now hits. A write miss therefore allocates the line first and merges the word afterwards, along the normal write-hit path. The processor keeps its request, address and data stable while stall is high. An access completes in a cycle where the request is high and stall is low.

Top module: `dm_cache`

## Requirements
- R1: After reset every line is invalid. With no request, stall and mem_req are low, and the first access to any line misses.
- R2: A read is a hit when the indexed line is valid and its stored tag equals address bits [31:IDX_LSB+IDX_W]. A read hit completes with stall low in the cycle it is presented, and no memory transaction is made.
- R3: The line index is taken from address bits [IDX_LSB+IDX_W-1:IDX_LSB], where IDX_LSB = 4 with four words per block. Address bits [3:2] pick the word from the block: word k sits in block bits [32k+31:32k]. A read returns the word stored at its own address.
- R4: On a read miss, stall is high from the first cycle. Exactly one block read is issued, and its mem_addr has the low 4 bits cleared. The returned block is installed, and the replayed read completes with the word from memory.
- R5: On a write miss, the whole block is fetched first and the written word is then merged into it. Later reads of the other words in that block return the values held in memory.
- R6: A write, whether it hits or misses, keeps stall high until exactly one word write is accepted by memory. That write has mem_addr equal to the word-aligned address and mem_wdata equal to the written data. The cache copy also holds the new word.
- R7: Two addresses with the same index and different tags evict each other. Going back to the first address misses again and refetches its block.
- R8: mem_req stays high, with mem_addr and mem_we unchanged, until mem_ready is seen. A read finishes when mem_rvalid returns the block.
- R9: While idle with no request, stall is low and no memory request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears all valid flags |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | 32 | Write word |
| cpu_rdata | output | 32 | Read word, valid when the read completes |
| cpu_stall | output | 1 | Holds the processor |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = word write, 0 = block read |
| mem_addr | output | ADDR_W | Block address (read) or word address (write) |
| mem_wdata | output | 32 | Write-through word |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Block read data valid |
| mem_rdata | input | 32*WORDS | Returned block |

## Verification
Reads are tried as a cold miss, as repeated hits to one word, and as a walk over all words of a loaded block. This sets hit timing apart from word selection. Two addresses sharing an index are alternated, so that true eviction can be told apart from a cache that wrongly matches on the index alone. Writes are tried both on a loaded line and on an absent line, and the neighbour words are read back afterwards. This shows whether a write miss allocated the block before merging, and whether every write reached memory exactly once.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_FILL  = 2'd2,
        ST_WRMEM = 2'd3
    } dmc_state_e;
endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
    parameter int LINES = 4096,
    parameter int TAG_W = 16,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag
);
    logic [LINES-1:0] valid_q;
    logic [TAG_W-1:0] tag_mem [LINES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx] <= wr_tag;
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_mem[rd_idx];
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
    parameter int LINES  = 4096,
    parameter int WORDS  = 4,
    parameter int WORD_W = 32,
    localparam int IDX_W = $clog2(LINES),
    localparam int OFF_W = $clog2(WORDS)
) (
    input  logic                    clk,
    input  logic [IDX_W-1:0]        rd_idx,
    output logic [WORDS*WORD_W-1:0] rd_block,
    input  logic                    fill_en,
    input  logic [IDX_W-1:0]        fill_idx,
    input  logic [WORDS*WORD_W-1:0] fill_block,
    input  logic                    word_en,
    input  logic [IDX_W-1:0]        word_idx,
    input  logic [OFF_W-1:0]        word_sel,
    input  logic [WORD_W-1:0]       word_data
);
    for (genvar w = 0; w < WORDS; w++) begin : g_bank
        logic [WORD_W-1:0] bank [LINES];

        always_ff @(posedge clk) begin
            if (fill_en) begin
                bank[fill_idx] <= fill_block[w*WORD_W +: WORD_W];
            end else if (word_en && (word_sel == OFF_W'(w))) begin
                bank[word_idx] <= word_data;
            end
        end

        assign rd_block[w*WORD_W +: WORD_W] = bank[rd_idx];
    end
endmodule

// File: rtl/dmc_word_pick.sv
module dmc_word_pick #(
    parameter int WORDS  = 4,
    parameter int WORD_W = 32,
    localparam int OFF_W = $clog2(WORDS)
) (
    input  logic [WORDS*WORD_W-1:0] block,
    input  logic [OFF_W-1:0]        sel,
    output logic [WORD_W-1:0]       word
);
    always_comb begin
        word = '0;
        for (int i = 0; i < WORDS; i++) begin
            if (sel == OFF_W'(i)) begin
                word = block[i*WORD_W +: WORD_W];
            end
        end
    end
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl #(
    parameter int ADDR_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic               we,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [31:0]        wdata,
    input  logic               hit,
    input  logic               mem_ready,
    input  logic               mem_rvalid,
    output logic               stall,
    output logic               fill_en,
    output logic               word_en,
    output logic [ADDR_W-1:0]  lat_addr,
    output logic [31:0]        lat_wdata,
    output dmc_pkg::dmc_state_e state_o
);
    import dmc_pkg::*;

    typedef struct packed {
        dmc_state_e        state;
        logic [ADDR_W-1:0] addr;
        logic [31:0]       wdata;
    } ctrl_t;

    ctrl_t cur_q, nxt_d;

    always_comb begin
        nxt_d   = cur_q;
        stall   = 1'b0;
        fill_en = 1'b0;
        word_en = 1'b0;
        unique case (cur_q.state)
            ST_IDLE: begin
                if (req) begin
                    if (!hit) begin
                        stall       = 1'b1;
                        nxt_d.state = ST_FETCH;
                        nxt_d.addr  = addr;
                    end else if (we) begin
                        stall       = 1'b1;
                        word_en     = 1'b1;
                        nxt_d.state = ST_WRMEM;
                        nxt_d.addr  = addr;
                        nxt_d.wdata = wdata;
                    end
                end
            end
            ST_FETCH: begin
                stall = 1'b1;
                if (mem_ready) nxt_d.state = ST_FILL;
            end
            ST_FILL: begin
                stall = 1'b1;
                if (mem_rvalid) begin
                    fill_en     = 1'b1;
                    nxt_d.state = ST_IDLE;
                end
            end
            ST_WRMEM: begin
                stall = !mem_ready;
                if (mem_ready) nxt_d.state = ST_IDLE;
            end
            default: nxt_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{state: ST_IDLE, addr: '0, wdata: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign lat_addr  = cur_q.addr;
    assign lat_wdata = cur_q.wdata;
    assign state_o   = cur_q.state;
endmodule

// File: rtl/dm_cache.sv
module dm_cache #(
    parameter int ADDR_W = 32,
    parameter int LINES  = 4096,
    parameter int WORDS  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cpu_req,
    input  logic                 cpu_we,
    input  logic [ADDR_W-1:0]    cpu_addr,
    input  logic [31:0]          cpu_wdata,
    output logic [31:0]          cpu_rdata,
    output logic                 cpu_stall,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [31:0]          mem_wdata,
    input  logic                 mem_ready,
    input  logic                 mem_rvalid,
    input  logic [32*WORDS-1:0]  mem_rdata
);
    import dmc_pkg::*;

    localparam int WORD_W  = 32;
    localparam int BYTE_W  = 2;
    localparam int OFF_W   = $clog2(WORDS);
    localparam int BLK_LSB = BYTE_W + OFF_W;
    localparam int IDX_W   = $clog2(LINES);
    localparam int TAG_LSB = BLK_LSB + IDX_W;
    localparam int TAG_W   = ADDR_W - TAG_LSB;

    logic [IDX_W-1:0]        cpu_idx, fill_idx;
    logic [TAG_W-1:0]        cpu_tag, fill_tag, line_tag;
    logic [OFF_W-1:0]        cpu_off;
    logic                    line_valid, hit;
    logic                    fill_en, word_en;
    logic [ADDR_W-1:0]       lat_addr;
    logic [31:0]             lat_wdata;
    logic [WORDS*WORD_W-1:0] line_block;
    dmc_state_e              ctrl_state;

    assign cpu_idx  = cpu_addr[BLK_LSB +: IDX_W];
    assign cpu_tag  = cpu_addr[TAG_LSB +: TAG_W];
    assign cpu_off  = cpu_addr[BYTE_W +: OFF_W];
    assign fill_idx = lat_addr[BLK_LSB +: IDX_W];
    assign fill_tag = lat_addr[TAG_LSB +: TAG_W];
    assign hit      = line_valid && (line_tag == cpu_tag);

    dmc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (cpu_idx),
        .rd_valid (line_valid),
        .rd_tag   (line_tag),
        .wr_en    (fill_en),
        .wr_idx   (fill_idx),
        .wr_tag   (fill_tag)
    );

    dmc_data_store #(.LINES(LINES), .WORDS(WORDS), .WORD_W(WORD_W)) u_data (
        .clk        (clk),
        .rd_idx     (cpu_idx),
        .rd_block   (line_block),
        .fill_en    (fill_en),
        .fill_idx   (fill_idx),
        .fill_block (mem_rdata),
        .word_en    (word_en),
        .word_idx   (cpu_idx),
        .word_sel   (cpu_off),
        .word_data  (cpu_wdata)
    );

    dmc_word_pick #(.WORDS(WORDS), .WORD_W(WORD_W)) u_pick (
        .block (line_block),
        .sel   (cpu_off),
        .word  (cpu_rdata)
    );

    dmc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (cpu_req),
        .we         (cpu_we),
        .addr       (cpu_addr),
        .wdata      (cpu_wdata),
        .hit        (hit),
        .mem_ready  (mem_ready),
        .mem_rvalid (mem_rvalid),
        .stall      (cpu_stall),
        .fill_en    (fill_en),
        .word_en    (word_en),
        .lat_addr   (lat_addr),
        .lat_wdata  (lat_wdata),
        .state_o    (ctrl_state)
    );

    assign mem_req   = (ctrl_state == ST_FETCH) || (ctrl_state == ST_WRMEM);
    assign mem_we    = (ctrl_state == ST_WRMEM);
    assign mem_wdata = lat_wdata;
    assign mem_addr  = mem_we ? {lat_addr[ADDR_W-1:BYTE_W], {BYTE_W{1'b0}}}
                              : {lat_addr[ADDR_W-1:BLK_LSB], {BLK_LSB{1'b0}}};

    logic unused_bits;
    assign unused_bits = ^{cpu_addr[BYTE_W-1:0], lat_addr[BYTE_W-1:0]};
endmodule

// File: rtl/dmc_checker.sv
module dmc_checker #(
    parameter int ADDR_W  = 32,
    parameter int BLK_LSB = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cpu_req,
    input logic               cpu_stall,
    input logic               mem_req,
    input logic               mem_we,
    input logic               mem_ready,
    input logic               mem_rvalid,
    input logic [ADDR_W-1:0]  mem_addr,
    input dmc_pkg::dmc_state_e state
);
    import dmc_pkg::*;

    assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    assert_fetch_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> (cpu_stall && (mem_addr[BLK_LSB-1:0] == '0)));

    assert_wt_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && !mem_ready) |-> cpu_stall);

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !cpu_req) |-> (!cpu_stall && !mem_req));

    assert_fill_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILL && mem_rvalid) |=> (state == ST_IDLE));
endmodule

bind dm_cache dmc_checker #(.ADDR_W(ADDR_W), .BLK_LSB(BLK_LSB)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_req    (cpu_req),
    .cpu_stall  (cpu_stall),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_ready  (mem_ready),
    .mem_rvalid (mem_rvalid),
    .mem_addr   (mem_addr),
    .state      (ctrl_state)
);

// File: tb/tb_dm_cache.sv
module tb_dm_cache;
    localparam int ADDR_W = 32;
    localparam int LINES  = 16;
    localparam int WORDS  = 4;
    localparam int LAT    = 2;
    localparam int IDXW   = $clog2(LINES);

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cpu_req = 1'b0, cpu_we = 1'b0;
    logic [ADDR_W-1:0]  cpu_addr = '0;
    logic [31:0]        cpu_wdata = '0;
    logic [31:0]        cpu_rdata;
    logic               cpu_stall;
    logic               mem_req, mem_we;
    logic [ADDR_W-1:0]  mem_addr;
    logic [31:0]        mem_wdata;
    logic               mem_ready, mem_rvalid;
    logic [32*WORDS-1:0] mem_rdata;

    always #2 clk = ~clk;

    dm_cache #(.ADDR_W(ADDR_W), .LINES(LINES), .WORDS(WORDS)) dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_stall(cpu_stall), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    int total = 0, bad = 0;
    int n_rd = 0, n_wr = 0;
    logic [31:0] exp_blk, exp_wt_addr, exp_wt_data;
    logic [31:0] mainmem [logic [29:0]];
    logic [31:0] golden  [logic [29:0]];
    bit          vtab [LINES];
    int unsigned ttab [LINES];

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    function automatic logic [31:0] initw(input logic [29:0] w);
        return ({w, 2'b00} * 32'h9E37_79B1) + 32'h1357_2468;
    endfunction

    function automatic logic [31:0] rd_main(input logic [29:0] w);
        return mainmem.exists(w) ? mainmem[w] : initw(w);
    endfunction

    function automatic logic [31:0] rd_gold(input logic [29:0] w);
        return golden.exists(w) ? golden[w] : initw(w);
    endfunction

    // memory model with fixed latency
    int          wait_cnt, ret_cnt;
    logic        rd_pend;
    logic [31:0] rd_base;
    logic        prev_wait;
    logic [31:0] prev_addr;

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ready  <= 1'b0;
            mem_rvalid <= 1'b0;
            mem_rdata  <= '0;
            wait_cnt   <= 0;
            ret_cnt    <= 0;
            rd_pend    <= 1'b0;
            prev_wait  <= 1'b0;
        end else begin
            // R8: request held stable until accepted
            if (prev_wait)
                check(mem_req && (mem_addr == prev_addr), "R8", "held request", mem_addr, prev_addr);
            prev_wait <= mem_req && !mem_ready;
            prev_addr <= mem_addr;
            mem_rvalid <= 1'b0;
            if (mem_req && mem_ready) begin
                mem_ready <= 1'b0;
                wait_cnt  <= 0;
                if (mem_we) begin
                    n_wr++;
                    check(mem_addr == exp_wt_addr, "R6", "write-through addr", mem_addr, exp_wt_addr);
                    check(mem_wdata == exp_wt_data, "R6", "write-through data", mem_wdata, exp_wt_data);
                    mainmem[mem_addr[31:2]] = mem_wdata;
                end else begin
                    n_rd++;
                    check(mem_addr == exp_blk, "R4", "fetch block addr", mem_addr, exp_blk);
                    rd_pend <= 1'b1;
                    rd_base <= mem_addr;
                    ret_cnt <= 0;
                end
            end else if (mem_req && !mem_ready && !rd_pend) begin
                if (wait_cnt == LAT) mem_ready <= 1'b1;
                else wait_cnt <= wait_cnt + 1;
            end
            if (rd_pend) begin
                if (ret_cnt == LAT) begin
                    for (int k = 0; k < WORDS; k++)
                        mem_rdata[32*k +: 32] <= rd_main({rd_base[31:4], 2'(k)});
                    mem_rvalid <= 1'b1;
                    rd_pend    <= 1'b0;
                end else begin
                    ret_cnt <= ret_cnt + 1;
                end
            end
        end
    end

    task automatic access(input bit w, input logic [31:0] a, input logic [31:0] d,
                          input string rq);
        logic [29:0] wa;
        int unsigned idx, tg;
        bit phit, first;
        int rd0, wr0, guard;
        wa    = a[31:2];
        idx   = (a >> 4) % LINES;
        tg    = a >> (4 + IDXW);
        phit  = vtab[idx] && (ttab[idx] == tg);
        rd0   = n_rd;
        wr0   = n_wr;
        first = 1'b1;
        guard = 0;
        exp_blk     = {a[31:4], 4'b0000};
        exp_wt_addr = {a[31:2], 2'b00};
        exp_wt_data = d;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = w; cpu_addr = a; cpu_wdata = d;
        forever begin
            #1;
            if (first) begin
                check(cpu_stall == (!phit || w), rq, "first-cycle stall",
                      32'(cpu_stall), 32'(!phit || w));
                first = 1'b0;
            end
            if (!cpu_stall) begin
                if (!w) check(cpu_rdata == rd_gold(wa), rq, "read data", cpu_rdata, rd_gold(wa));
                break;
            end
            guard++;
            if (guard > 60) begin
                check(1'b0, rq, "access never completed", 32'(guard), 32'd60);
                break;
            end
            @(negedge clk);
        end
        @(posedge clk);
        #1;
        cpu_req = 1'b0;
        check((n_rd - rd0) == (phit ? 0 : 1), rq, "block fetch count", 32'(n_rd - rd0), phit ? 32'd0 : 32'd1);
        check((n_wr - wr0) == (w ? 1 : 0), w ? "R6" : rq, "word write count", 32'(n_wr - wr0), w ? 32'd1 : 32'd0);
        vtab[idx] = 1'b1;
        ttab[idx] = tg;
        if (w) golden[wa] = d;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "R8", "watchdog expired", 32'd0, 32'd1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < LINES; i++) begin vtab[i] = 1'b0; ttab[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R1 / R9: quiet after reset
        check(!cpu_stall, "R1", "stall after reset", 32'(cpu_stall), 32'd0);
        check(!mem_req, "R9", "mem_req after reset", 32'(mem_req), 32'd0);

        access(1'b0, 32'h0000_0100, 32'h0, "R1");   // cold miss
        access(1'b0, 32'h0000_0100, 32'h0, "R2");   // repeated hit
        access(1'b0, 32'h0000_0104, 32'h0, "R3");   // other words of block
        access(1'b0, 32'h0000_0108, 32'h0, "R3");
        access(1'b0, 32'h0000_010C, 32'h0, "R3");
        access(1'b0, 32'h0000_1100, 32'h0, "R7");   // same index, new tag
        access(1'b0, 32'h0000_0104, 32'h0, "R7");   // evicted: misses again
        access(1'b0, 32'h0000_0140, 32'h0, "R4");   // plain read miss
        access(1'b1, 32'h0000_0104, 32'hCAFE_0001, "R6"); // write hit
        access(1'b0, 32'h0000_0104, 32'h0, "R6");
        access(1'b1, 32'h0000_2234, 32'hBEEF_0002, "R5"); // write miss
        access(1'b0, 32'h0000_2230, 32'h0, "R5");
        access(1'b0, 32'h0000_2234, 32'h0, "R5");
        access(1'b0, 32'h0000_2238, 32'h0, "R5");
        access(1'b0, 32'h0000_223C, 32'h0, "R5");
        access(1'b0, 32'h0000_0134, 32'h0, "R7");   // conflicts with 0x2234
        access(1'b0, 32'h0000_2234, 32'h0, "R7");   // refetched with merged word
        for (int i = 0; i < 12; i++) begin
            access(1'b1, 32'h0000_3000 + 32'(i * 'h24), 32'h5A00_0000 + 32'(i), "R6");
        end
        for (int i = 0; i < 12; i++) begin
            access(1'b0, 32'h0000_3000 + 32'(i * 'h24), 32'h0, "R3");
        end
        @(negedge clk); #1;
        check(!cpu_stall && !mem_req, "R9", "idle without request",
              32'({cpu_stall, mem_req}), 32'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule